// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps time of day and a running day number from a one-second tick pulse. Seconds and minutes are held as two-digit BCD values from 00 to 59. Hours are BCD from 00 to 23. Above the hours sits a free-running binary day number, split into a low byte and a high byte. Each tick that arrives while the calendar runs moves the seconds forward. Any carry ripples through minutes, hours and day within the same clock cycle.

Software reaches the block through a byte-wide register port: an address, a write strobe, write data and a combinational read-back. A control byte holds the run switch, the alarm enables and the alarm flag. It also carries a read-only busy bit, which marks the cycle in which the counter is updating. An alarm compare on minute, hour and day raises a sticky flag, and a level interrupt follows that flag when its enable is set.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset every register reads 0x00 and `alarm_irq` is low.
- R2: A tick accepted while the run bit is 1 advances seconds by one BCD step. Seconds wrap 59→00 with a carry into minutes, minutes wrap 59→00 with a carry into hours, and hours wrap 23→00 with a carry into the day number, all in one cycle.
- R3: The day number is a 15-bit binary count at address 0x4 (bits 7:0) and 0x5 (bits 14:8, read with bit 7 as 0). It wraps from 0x7FFF to 0.
- R4: While the run bit (control bit 0) is 0, ticks change no time field.
- R5: Control bit 7 reads 1 exactly in a cycle where a tick arrives with the run bit set, and reads 0 otherwise. Writes to bit 7 have no effect.
- R6: A write to a time field in the same cycle as an accepted tick lands after the update: the written field holds the written value, and the other fields still advance.
- R7: A field at or above its top value (0x59 or 0x23, compared as a byte) wraps to 00 with a carry on the next step. A low digit of 9 or more steps to the next tens with a low digit of 0. Out-of-range stored values therefore never stall the count.
- R8: The alarm is checked only in the cycle where seconds step to 00, against the new minute, hour and day values. The flag (control bit 2) is set when at least one of the minute (bit 3), hour (bit 4) or day (bit 5) enables is on and every enabled field matches.
- R9: Writing control with bit 2 at 1 clears the alarm flag, and writing 0 there leaves it alone. A match in the same cycle wins over the clear.
- R10: `alarm_irq` is high exactly when the alarm flag is set and the interrupt enable (control bit 1) is 1.
- R11: Address map: 0x0 control, 0x1 seconds, 0x2 minutes, 0x3 hours, 0x4/0x5 day low/high, 0x6 alarm minute, 0x7 alarm hour, 0x8/0x9 alarm day low/high. The alarm registers read back what was written, and unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| alarm_irq | output | 1 | Alarm interrupt request (level) |

## Verification
The count is driven from seeds that sit right below each wrap point: 58/59 seconds, 59 minutes, hour 23 and day 0x7FFF. These show whether the carry ripples through every field in one step and whether the day wraps cleanly. The seeds also include invalid BCD values such as 0x5A, 0x3C and 0xFF, which separate a design that merely tests for equality with the top value from one that cannot stall. The alarm is tried with single-field, day-only and no-enable setups. It is also tried with a clear written in the very cycle of a match, and with ticks that stay inside the matched minute. Together these separate edge-triggered matching from level matching and show the set-over-clear priority.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] A_CTRL    = 4'h0;
  localparam logic [REG_AW-1:0] A_SEC     = 4'h1;
  localparam logic [REG_AW-1:0] A_MIN     = 4'h2;
  localparam logic [REG_AW-1:0] A_HOUR    = 4'h3;
  localparam logic [REG_AW-1:0] A_DAY_LO  = 4'h4;
  localparam logic [REG_AW-1:0] A_DAY_HI  = 4'h5;
  localparam logic [REG_AW-1:0] A_AMIN    = 4'h6;
  localparam logic [REG_AW-1:0] A_AHOUR   = 4'h7;
  localparam logic [REG_AW-1:0] A_ADAY_LO = 4'h8;
  localparam logic [REG_AW-1:0] A_ADAY_HI = 4'h9;

  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_IRQ_EN = 1;
  localparam int unsigned CB_FLAG   = 2;
  localparam int unsigned CB_MIN_EN = 3;
  localparam int unsigned CB_HR_EN  = 4;
  localparam int unsigned CB_DAY_EN = 5;

  localparam logic [7:0] SEC_LAST  = 8'h59;
  localparam logic [7:0] MIN_LAST  = 8'h59;
  localparam logic [7:0] HOUR_LAST = 8'h23;

  typedef struct packed {
    logic day_en;
    logic hr_en;
    logic min_en;
    logic irq_en;
    logic run;
  } ctrl_t;

  // {carry, next value}: wrap at or above the top value, else a BCD step
  function automatic logic [8:0] bcd_advance(input logic [7:0] cur,
                                             input logic [7:0] last);
    logic [3:0] tens;
    tens = cur[7:4] + 4'd1;
    if (cur >= last)
      return 9'h100;
    else if (cur[3:0] >= 4'd9)
      return {1'b0, tens, 4'd0};
    else
      return {1'b0, cur[7:4], cur[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter logic [7:0] LAST = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] value,
  output logic [7:0] value_next,
  output logic       carry
);
  logic [8:0] adv;

  assign adv        = bcd_advance(value, LAST);
  assign value_next = step ? adv[7:0] : value;
  assign carry      = step & adv[8];

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= 8'h00;
    else if (wr_en) value <= wr_data;
    else            value <= value_next;
  end
endmodule

// File: rtl/cal_day_count.sv
module cal_day_count #(
  parameter int unsigned DAY_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [7:0]          wr_lo_data,
  input  logic [DAY_W-9:0]    wr_hi_data,
  output logic [DAY_W-1:0]    value,
  output logic [DAY_W-1:0]    value_next
);
  logic [DAY_W-1:0] merged;

  assign value_next = step ? DAY_W'(value + 1'b1) : value;

  always_comb begin
    merged = value_next;
    if (wr_lo) merged[7:0]       = wr_lo_data;
    if (wr_hi) merged[DAY_W-1:8] = wr_hi_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= merged;
  end
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit #(
  parameter int unsigned DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_min,
  input  logic             wr_hr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  input  logic             eval,
  input  logic             min_en,
  input  logic             hr_en,
  input  logic             day_en,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hr,
  input  logic [DAY_W-1:0] cur_day,
  output logic [7:0]       alm_min,
  output logic [7:0]       alm_hr,
  output logic [DAY_W-1:0] alm_day,
  output logic             hit
);
  logic any_en, min_ok, hr_ok, day_ok;

  assign any_en = min_en | hr_en | day_en;
  assign min_ok = !min_en || (cur_min == alm_min);
  assign hr_ok  = !hr_en  || (cur_hr  == alm_hr);
  assign day_ok = !day_en || (cur_day == alm_day);
  assign hit    = eval & any_en & min_ok & hr_ok & day_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_min <= 8'h00;
      alm_hr  <= 8'h00;
      alm_day <= '0;
    end else begin
      if (wr_min) alm_min <= wr_data;
      if (wr_hr)  alm_hr  <= wr_data;
      if (wr_lo)  alm_day[7:0] <= wr_data;
      if (wr_hi)  alm_day[DAY_W-1:8] <= wr_data[DAY_W-9:0];
    end
  end
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
#(
  parameter int unsigned DAY_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              alarm_irq
);
  localparam int unsigned HI_PAD = 16 - DAY_W;

  ctrl_t            ctrl_q;
  logic             alm_flag_q;
  logic             wr_ctrl, wr_sec, wr_min, wr_hr, wr_dlo, wr_dhi;
  logic             wr_amin, wr_ahr, wr_alo, wr_ahi;
  logic             cal_busy, step_sec, carry_sec, carry_min, carry_hr;
  logic             alarm_eval, alarm_hit;
  logic [7:0]       sec_q, min_q, hr_q, sec_nx, min_nx, hr_nx;
  logic [7:0]       amin_q, ahr_q;
  logic [DAY_W-1:0] day_q, day_nx, aday_q;

  // register decode
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_sec  = reg_wr && (reg_addr == A_SEC);
  assign wr_min  = reg_wr && (reg_addr == A_MIN);
  assign wr_hr   = reg_wr && (reg_addr == A_HOUR);
  assign wr_dlo  = reg_wr && (reg_addr == A_DAY_LO);
  assign wr_dhi  = reg_wr && (reg_addr == A_DAY_HI);
  assign wr_amin = reg_wr && (reg_addr == A_AMIN);
  assign wr_ahr  = reg_wr && (reg_addr == A_AHOUR);
  assign wr_alo  = reg_wr && (reg_addr == A_ADAY_LO);
  assign wr_ahi  = reg_wr && (reg_addr == A_ADAY_HI);

  // carry chain
  assign step_sec   = sec_tick & ctrl_q.run;
  assign cal_busy   = step_sec;
  assign alarm_eval = carry_sec;

  cal_bcd_field #(.LAST(SEC_LAST)) u_sec (
    .clk(clk), .rst_n(rst_n), .step(step_sec), .wr_en(wr_sec),
    .wr_data(reg_wdata), .value(sec_q), .value_next(sec_nx), .carry(carry_sec));

  cal_bcd_field #(.LAST(MIN_LAST)) u_min (
    .clk(clk), .rst_n(rst_n), .step(carry_sec), .wr_en(wr_min),
    .wr_data(reg_wdata), .value(min_q), .value_next(min_nx), .carry(carry_min));

  cal_bcd_field #(.LAST(HOUR_LAST)) u_hour (
    .clk(clk), .rst_n(rst_n), .step(carry_min), .wr_en(wr_hr),
    .wr_data(reg_wdata), .value(hr_q), .value_next(hr_nx), .carry(carry_hr));

  cal_day_count #(.DAY_W(DAY_W)) u_day (
    .clk(clk), .rst_n(rst_n), .step(carry_hr), .wr_lo(wr_dlo), .wr_hi(wr_dhi),
    .wr_lo_data(reg_wdata), .wr_hi_data(reg_wdata[DAY_W-9:0]),
    .value(day_q), .value_next(day_nx));

  cal_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .wr_min(wr_amin), .wr_hr(wr_ahr),
    .wr_lo(wr_alo), .wr_hi(wr_ahi), .wr_data(reg_wdata), .eval(alarm_eval),
    .min_en(ctrl_q.min_en), .hr_en(ctrl_q.hr_en), .day_en(ctrl_q.day_en),
    .cur_min(min_nx), .cur_hr(hr_nx), .cur_day(day_nx),
    .alm_min(amin_q), .alm_hr(ahr_q), .alm_day(aday_q), .hit(alarm_hit));

  // control byte and alarm flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      alm_flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run    <= reg_wdata[CB_RUN];
        ctrl_q.irq_en <= reg_wdata[CB_IRQ_EN];
        ctrl_q.min_en <= reg_wdata[CB_MIN_EN];
        ctrl_q.hr_en  <= reg_wdata[CB_HR_EN];
        ctrl_q.day_en <= reg_wdata[CB_DAY_EN];
      end
      if (alarm_hit)
        alm_flag_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[CB_FLAG])
        alm_flag_q <= 1'b0;
    end
  end

  assign alarm_irq = alm_flag_q & ctrl_q.irq_en;

  // read-back
  always_comb begin
    case (reg_addr)
      A_CTRL:    reg_rdata = {cal_busy, 1'b0, ctrl_q.day_en, ctrl_q.hr_en,
                              ctrl_q.min_en, alm_flag_q, ctrl_q.irq_en, ctrl_q.run};
      A_SEC:     reg_rdata = sec_q;
      A_MIN:     reg_rdata = min_q;
      A_HOUR:    reg_rdata = hr_q;
      A_DAY_LO:  reg_rdata = day_q[7:0];
      A_DAY_HI:  reg_rdata = {{HI_PAD{1'b0}}, day_q[DAY_W-1:8]};
      A_AMIN:    reg_rdata = amin_q;
      A_AHOUR:   reg_rdata = ahr_q;
      A_ADAY_LO: reg_rdata = aday_q[7:0];
      A_ADAY_HI: reg_rdata = {{HI_PAD{1'b0}}, aday_q[DAY_W-1:8]};
      default:   reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cal_timekeeper_chk.sv
module cal_timekeeper_chk #(
  parameter int unsigned DAY_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             wr_sec,
  input logic             wr_ctrl,
  input logic             clr_bit,
  input logic             run,
  input logic             cal_busy,
  input logic             day_step,
  input logic             alarm_eval,
  input logic             alarm_hit,
  input logic             alm_flag,
  input logic [7:0]       sec_q,
  input logic [7:0]       min_q,
  input logic [DAY_W-1:0] day_q
);
  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_wr) |=> $stable(sec_q));

  assert_busy_moves_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !wr_sec) |=> (sec_q != $past(sec_q)));

  assert_minute_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && sec_q == 8'h59 && min_q == 8'h59 && !reg_wr)
      |=> (sec_q == 8'h00 && min_q == 8'h00));

  assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && day_q == {DAY_W{1'b1}} && !reg_wr) |=> (day_q == '0));

  assert_flag_after_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past(alarm_eval));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && clr_bit && !alarm_hit) |=> !alm_flag);
endmodule

bind cal_timekeeper cal_timekeeper_chk #(.DAY_W(DAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_sec(wr_sec),
  .wr_ctrl(wr_ctrl), .clr_bit(reg_wdata[2]), .run(ctrl_q.run),
  .cal_busy(cal_busy), .day_step(carry_hr), .alarm_eval(alarm_eval),
  .alarm_hit(alarm_hit), .alm_flag(alm_flag_q), .sec_q(sec_q),
  .min_q(min_q), .day_q(day_q));

// File: tb/test_cal_timekeeper.sv
module test_cal_timekeeper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       alarm_irq;

  int compared = 0;
  int mismatched = 0;

  // reference state
  logic [7:0]  m_sec = 0, m_min = 0, m_hr = 0, m_amin = 0, m_ahr = 0;
  logic [14:0] m_day = 0, m_aday = 0;
  bit m_run = 0, m_irqen = 0, m_flag = 0, m_minen = 0, m_hren = 0, m_dayen = 0;

  always #5 clk = ~clk;

  cal_timekeeper i_cal_timekeeper (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_irq(alarm_irq));

  function automatic logic [7:0] adv(input logic [7:0] v, input int top, output bit c);
    int tens, ones;
    tens = v / 16;
    ones = v % 16;
    c = 0;
    if (int'(v) >= top) begin
      c = 1;
      return 8'h00;
    end
    if (ones >= 9) return 8'((tens + 1) * 16);
    return 8'(v + 1);
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a, input bit t);
    case (a)
      4'h0: return {t && m_run, 1'b0, m_dayen, m_hren, m_minen, m_flag, m_irqen, m_run};
      4'h1: return m_sec;
      4'h2: return m_min;
      4'h3: return m_hr;
      4'h4: return m_day[7:0];
      4'h5: return {1'b0, m_day[14:8]};
      4'h6: return m_amin;
      4'h7: return m_ahr;
      4'h8: return m_aday[7:0];
      4'h9: return {1'b0, m_aday[14:8]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_update(input bit t, input bit w, input logic [3:0] a, input logic [7:0] d);
    bit cs = 0, cm = 0, ch = 0, hit = 0;
    logic [7:0] ns = m_sec, nm = m_min, nh = m_hr;
    logic [14:0] nd = m_day;
    if (t && m_run) begin
      ns = adv(m_sec, 'h59, cs);
      if (cs) nm = adv(m_min, 'h59, cm);
      if (cm) nh = adv(m_hr, 'h23, ch);
      if (ch) nd = m_day + 15'd1;
      if (cs)
        hit = (m_minen || m_hren || m_dayen) && (!m_minen || nm == m_amin) &&
              (!m_hren || nh == m_ahr) && (!m_dayen || nd == m_aday);
    end
    if (hit) m_flag = 1;
    else if (w && a == 4'h0 && d[2]) m_flag = 0;
    if (w) begin
      case (a)
        4'h0: begin
          m_run = d[0]; m_irqen = d[1]; m_minen = d[3]; m_hren = d[4]; m_dayen = d[5];
        end
        4'h1: ns = d;
        4'h2: nm = d;
        4'h3: nh = d;
        4'h4: nd[7:0] = d;
        4'h5: nd[14:8] = d[6:0];
        4'h6: m_amin = d;
        4'h7: m_ahr = d;
        4'h8: m_aday[7:0] = d;
        4'h9: m_aday[14:8] = d[6:0];
        default: ;
      endcase
    end
    m_sec = ns; m_min = nm; m_hr = nh; m_day = nd;
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: drive at the falling edge, compare, then let the edge act
  task automatic cyc(input bit t, input bit w, input logic [3:0] a,
                     input logic [7:0] d, input string tag);
    sec_tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
    #1;
    check({tag, " rdata"}, reg_rdata, m_read(a, t));
    check("R10 irq", {7'd0, alarm_irq}, {7'd0, m_flag && m_irqen});
    @(posedge clk);
    m_update(t, w, a, d);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc(0, 1, a, d, tag);
  endtask
  task automatic rd(input logic [3:0] a, input string tag);
    cyc(0, 0, a, 8'h00, tag);
  endtask
  task automatic tk(input logic [3:0] a, input string tag);
    cyc(1, 0, a, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, R11 unused addresses
    for (int a = 0; a < 16; a++) rd(4'(a), "R1_R11 reset");
    // R11 alarm registers read back
    wr(4'h6, 8'h34, "R11"); wr(4'h7, 8'h12, "R11");
    wr(4'h8, 8'hA5, "R11"); wr(4'h9, 8'hFF, "R11");
    for (int a = 6; a < 10; a++) rd(4'(a), "R11 alarm readback");
    // R4 halted
    wr(4'h1, 8'h10, "R4");
    for (int i = 0; i < 3; i++) tk(4'h1, "R4 halted");
    tk(4'h0, "R5 busy low when halted");
    // R2/R3 full ripple and day wrap
    wr(4'h0, 8'h81, "R5 busy write ignored");
    rd(4'h0, "R5");
    wr(4'h1, 8'h58, "R2"); wr(4'h2, 8'h59, "R2"); wr(4'h3, 8'h23, "R2");
    wr(4'h4, 8'hFF, "R3"); wr(4'h5, 8'hFF, "R3");
    rd(4'h5, "R3 high byte bit7");
    tk(4'h0, "R5 busy high");
    tk(4'h1, "R2");
    rd(4'h1, "R2"); rd(4'h2, "R2"); rd(4'h3, "R2"); rd(4'h4, "R3"); rd(4'h5, "R3 wrap");
    for (int i = 0; i < 130; i++) tk(4'((i % 3) + 1), "R2 run");
    // R6 write in the busy cycle
    wr(4'h1, 8'h59, "R6");
    cyc(1, 1, 4'h1, 8'h30, "R6 write with tick");
    rd(4'h1, "R6"); rd(4'h2, "R6 minute stepped");
    // R7 out-of-range values
    wr(4'h1, 8'h5A, "R7"); tk(4'h1, "R7"); rd(4'h1, "R7"); rd(4'h2, "R7");
    wr(4'h1, 8'h3C, "R7"); tk(4'h1, "R7"); rd(4'h1, "R7 digit");
    wr(4'h3, 8'hFF, "R7"); wr(4'h2, 8'h59, "R7"); wr(4'h1, 8'h59, "R7");
    tk(4'h3, "R7"); rd(4'h3, "R7 hour"); rd(4'h4, "R7 day");
    // R8 minute alarm, R10 irq
    wr(4'h6, 8'h05, "R8"); wr(4'h2, 8'h04, "R8"); wr(4'h1, 8'h58, "R8");
    wr(4'h0, 8'h0B, "R8");
    tk(4'h0, "R8"); tk(4'h0, "R8 fire"); rd(4'h0, "R8 flag");
    for (int i = 0; i < 4; i++) tk(4'h0, "R8 same minute");
    // R9 write 0 keeps, write 1 clears
    wr(4'h0, 8'h0B, "R9 zero keeps"); rd(4'h0, "R9");
    wr(4'h0, 8'h0F, "R9 clear"); rd(4'h0, "R9");
    for (int i = 0; i < 5; i++) tk(4'h0, "R8 once per minute");
    // R10 irq disabled with flag set
    wr(4'h1, 8'h59, "R10"); wr(4'h2, 8'h04, "R10"); wr(4'h0, 8'h09, "R10");
    tk(4'h0, "R10"); rd(4'h0, "R10 masked");
    wr(4'h0, 8'h0B, "R10 unmask"); rd(4'h0, "R10");
    // R9 set beats clear
    wr(4'h0, 8'h0F, "R9"); wr(4'h1, 8'h59, "R9"); wr(4'h2, 8'h04, "R9");
    cyc(1, 1, 4'h0, 8'h0F, "R9 set wins"); rd(4'h0, "R9");
    // R8 no enables: no flag
    wr(4'h0, 8'h07, "R8"); wr(4'h1, 8'h59, "R8"); wr(4'h2, 8'h04, "R8");
    tk(4'h0, "R8"); rd(4'h0, "R8 no enable");
    // R8 hour mismatch blocks
    wr(4'h0, 8'h1B, "R8"); wr(4'h7, 8'h09, "R8"); wr(4'h1, 8'h59, "R8");
    wr(4'h2, 8'h04, "R8"); tk(4'h0, "R8"); rd(4'h0, "R8 hour mismatch");
    // R8 day alarm on hour rollover into a new day
    wr(4'h0, 8'h23, "R8"); wr(4'h8, 8'h00, "R8"); wr(4'h9, 8'h01, "R8");
    wr(4'h5, 8'h00, "R8"); wr(4'h4, 8'hFF, "R8");
    wr(4'h3, 8'h23, "R8"); wr(4'h2, 8'h59, "R8"); wr(4'h1, 8'h59, "R8");
    tk(4'h4, "R8 day"); rd(4'h0, "R8 day flag"); rd(4'h5, "R3 carry into high byte");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule